// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block takes a single operand request of one, two, three or four bytes from internal logic and carries it out over a 16-bit external data bus. The responding device reports its port width with each cycle's acknowledge, as 8 or 16 bits. The sequencer therefore breaks the operand into as many bus cycles as that width requires. Every cycle starts on the assumption of a 16-bit port and offers as many bytes as the address and the remaining count allow. The acknowledge then settles how many bytes the cycle actually moved.

Bytes travel most significant first. The address steps by the number of bytes moved in each cycle. A 2-bit size output tells the device how many operand bytes are still outstanding. Write bytes are placed on the lanes that either port width can pick up. Read bytes are shifted into an accumulator that is presented right-justified when the operand completes. A request for more than one byte at an odd address is turned away with an error pulse.

Top module: `dbs_sequencer`

## Requirements
- R1: After reset, bus_strobe, done and err are all low.
- R2: While bus_strobe is high, bus_addr holds the address of the next operand byte still to be moved, and bus_size holds the number of bytes still outstanding, encoded 01 = one, 10 = two, 11 = three, 00 = four. req_size uses the same encoding.
- R3: A request with req_size other than 01 and req_addr[0] = 1 is refused. err is high for exactly the one cycle after the request and no bus cycle starts. A one-byte request at an odd address is accepted.
- R4: An acknowledge of 00 is a wait state. bus_strobe, bus_addr, bus_size and bus_wdata then hold unchanged into the next cycle.
- R5: An acknowledge of 10 (16-bit port) at an even address with at least two bytes outstanding moves two bytes: upper lane [15:8] first, then lower lane [7:0]. The address rises by 2. A long word on a 16-bit port takes two cycles.
- R6: An acknowledge of 01 (8-bit port) moves one byte, always on lane [15:8], and the address rises by 1. A long word on an 8-bit port takes four cycles.
- R7: An acknowledge of 10 at an odd address moves one byte, on lane [7:0]. An acknowledge of 10 at an even address with one byte outstanding moves one byte, on lane [15:8].
- R8: For a write, bus_wdata carries the next outstanding byte on both lanes when the address is odd or only one byte remains. Otherwise it carries the next byte on [15:8] and the one after it on [7:0].
- R9: The cycle after the acknowledge that moves the last byte, done is high for exactly one cycle and bus_strobe is low. For a read, rdata then holds the operand right-justified, with the first byte moved as its most significant byte.
- R10: The port width may differ from cycle to cycle within one operand. Each cycle's byte count follows that cycle's own acknowledge.
- R11: A request presented while bus_strobe is high is ignored and does not disturb the operand in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request, sampled while idle |
| req_write | input | 1 | 1 = write operand, 0 = read operand |
| req_size | input | 2 | Operand length code (01/10/11/00 = 1/2/3/4 bytes) |
| req_addr | input | ADDR_W | Byte address of the operand's most significant byte |
| req_wdata | input | 32 | Write operand, right-justified |
| bus_strobe | output | 1 | A bus cycle is in progress |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_addr | output | ADDR_W | Byte address of the current cycle |
| bus_size | output | 2 | Bytes still outstanding, same code as req_size |
| bus_wdata | output | 16 | Write data lanes |
| bus_rdata | input | 16 | Read data lanes |
| bus_ack | input | 2 | 10 = 16-bit port, 01 = 8-bit port, 00 = wait |
| done | output | 1 | One-cycle pulse when the operand completes |
| err | output | 1 | One-cycle pulse on a misaligned request |
| rdata | output | 32 | Read operand, right-justified, valid with done |

## Verification
The hardest situation to reach is an operand that passes through an odd address partway through. This happens when an 8-bit acknowledge on the first byte leaves the next cycle odd, and a 16-bit acknowledge must then take a single byte from the lower lane. The bench reaches it with a per-cycle list of port widths, starting with one 8-bit answer followed by 16-bit answers, for both reads and writes. The responder checks the address, size code and lanes on every cycle. It also holds a wait state while a second request is pushed at the busy block, to show that the request is ignored.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int LANE_W = 16;
  localparam int OPER_W = 32;
  localparam int CNT_W  = 3;

  localparam logic [1:0] ACK_WAIT = 2'b00;
  localparam logic [1:0] ACK_P8   = 2'b01;
  localparam logic [1:0] ACK_P16  = 2'b10;

  typedef enum logic {ST_IDLE, ST_BUS} dbs_state_t;

  // length code to byte count: 00 stands for four bytes
  function automatic logic [CNT_W-1:0] size_to_count(input logic [1:0] code);
    return (code == 2'b00) ? CNT_W'(4) : {1'b0, code};
  endfunction

  // byte idx of a right-justified operand, idx 0 = least significant
  function automatic logic [7:0] pick_byte(input logic [OPER_W-1:0] w,
                                           input logic [1:0] idx);
    return w[{idx, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/dbs_step.sv
module dbs_step
  import dbs_pkg::*;
(
  input  logic [1:0]       ack,
  input  logic             addr0,
  input  logic [CNT_W-1:0] rem,
  output logic             acked,
  output logic             port16,
  output logic [1:0]       step
);

  always_comb begin
    port16 = ack[1];
    acked  = |ack;
    if (!acked)
      step = 2'd0;
    else if (!port16 || addr0 || rem == CNT_W'(1))
      step = 2'd1;
    else
      step = 2'd2;
  end

endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
  import dbs_pkg::*;
(
  input  logic              addr0,
  input  logic [CNT_W-1:0]  rem,
  input  logic [OPER_W-1:0] wbuf,
  output logic [LANE_W-1:0] lanes
);

  logic [1:0] idx_first;
  logic [1:0] idx_second;
  logic [7:0] b_first;
  logic [7:0] b_second;

  always_comb begin
    idx_first  = 2'(rem - CNT_W'(1));
    idx_second = 2'(rem - CNT_W'(2));
    b_first    = pick_byte(wbuf, idx_first);
    b_second   = pick_byte(wbuf, idx_second);
    if (addr0 || rem <= CNT_W'(1))
      lanes = {b_first, b_first};
    else
      lanes = {b_first, b_second};
  end

endmodule

// File: rtl/dbs_read_pack.sv
module dbs_read_pack
  import dbs_pkg::*;
(
  input  logic [1:0]        step,
  input  logic              port16,
  input  logic              addr0,
  input  logic [LANE_W-1:0] lanes,
  input  logic [OPER_W-1:0] acc_in,
  output logic [OPER_W-1:0] acc_out
);

  logic [7:0] single;

  always_comb begin
    single = (port16 && addr0) ? lanes[7:0] : lanes[15:8];
    case (step)
      2'd2:    acc_out = {acc_in[OPER_W-LANE_W-1:0], lanes};
      2'd1:    acc_out = {acc_in[OPER_W-8-1:0], single};
      default: acc_out = acc_in;
    endcase
  end

endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OPER_W-1:0] req_wdata,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [LANE_W-1:0] bus_wdata,
  input  logic [LANE_W-1:0] bus_rdata,
  input  logic [1:0]        bus_ack,
  output logic              done,
  output logic              err,
  output logic [OPER_W-1:0] rdata
);

  dbs_state_t        state_q, nxt_state;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [CNT_W-1:0]  rem_q, nxt_rem;
  logic [OPER_W-1:0] wbuf_q, nxt_wbuf;
  logic [OPER_W-1:0] acc_q, nxt_acc;
  logic              wr_q, nxt_wr;
  logic [LANE_W-1:0] wdata_q, nxt_lanes;
  logic              done_q, nxt_done;
  logic              err_q, nxt_err;
  logic [OPER_W-1:0] rdata_q, nxt_rdata;

  logic              acked;
  logic              port16;
  logic [1:0]        step;
  logic [OPER_W-1:0] packed_acc;

  dbs_step u_step (
    .ack    (bus_ack),
    .addr0  (addr_q[0]),
    .rem    (rem_q),
    .acked  (acked),
    .port16 (port16),
    .step   (step)
  );

  dbs_read_pack u_pack (
    .step    (step),
    .port16  (port16),
    .addr0   (addr_q[0]),
    .lanes   (bus_rdata),
    .acc_in  (acc_q),
    .acc_out (packed_acc)
  );

  // lanes are prepared from next-state values so bus_wdata leaves a register
  dbs_lane_steer u_steer (
    .addr0 (nxt_addr[0]),
    .rem   (nxt_rem),
    .wbuf  (nxt_wbuf),
    .lanes (nxt_lanes)
  );

  always_comb begin
    nxt_state = state_q;
    nxt_addr  = addr_q;
    nxt_rem   = rem_q;
    nxt_wbuf  = wbuf_q;
    nxt_acc   = acc_q;
    nxt_wr    = wr_q;
    nxt_done  = 1'b0;
    nxt_err   = 1'b0;
    nxt_rdata = rdata_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_size != 2'b01 && req_addr[0]) begin
            nxt_err = 1'b1;
          end else begin
            nxt_state = ST_BUS;
            nxt_addr  = req_addr;
            nxt_rem   = size_to_count(req_size);
            nxt_wbuf  = req_wdata;
            nxt_acc   = '0;
            nxt_wr    = req_write;
          end
        end
      end
      ST_BUS: begin
        if (acked) begin
          nxt_addr = addr_q + ADDR_W'(step);
          nxt_rem  = rem_q - {1'b0, step};
          nxt_acc  = packed_acc;
          if (nxt_rem == '0) begin
            nxt_state = ST_IDLE;
            nxt_done  = 1'b1;
            if (!wr_q) nxt_rdata = packed_acc;
          end
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      wbuf_q  <= '0;
      acc_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= nxt_state;
      addr_q  <= nxt_addr;
      rem_q   <= nxt_rem;
      wbuf_q  <= nxt_wbuf;
      acc_q   <= nxt_acc;
      wr_q    <= nxt_wr;
      wdata_q <= nxt_lanes;
      done_q  <= nxt_done;
      err_q   <= nxt_err;
      rdata_q <= nxt_rdata;
    end
  end

  assign bus_strobe = (state_q == ST_BUS);
  assign bus_write  = wr_q;
  assign bus_addr   = addr_q;
  assign bus_size   = rem_q[1:0];
  assign bus_wdata  = wdata_q;
  assign done       = done_q;
  assign err        = err_q;
  assign rdata      = rdata_q;

endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_strobe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [15:0]       bus_wdata,
  input logic [1:0]        bus_ack,
  input logic              done,
  input logic              err
);

  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    err |-> !bus_strobe && !done); // R3

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_ack == 2'b00 |=> bus_strobe && $stable(bus_addr)
      && $stable(bus_size) && $stable(bus_wdata)); // R4

  AST_P16_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_ack == 2'b10 && !bus_addr[0] && bus_size != 2'b01
      |=> bus_addr == ADDR_W'($past(bus_addr) + ADDR_W'(2))); // R5

  AST_P8_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_ack == 2'b01 && bus_size != 2'b01
      |=> bus_strobe && bus_addr == ADDR_W'($past(bus_addr) + ADDR_W'(1))
        && bus_size == 2'($past(bus_size) - 2'd1)); // R6

  AST_P16_ODD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_ack == 2'b10 && bus_addr[0] && bus_size != 2'b01
      |=> bus_strobe && bus_size == 2'($past(bus_size) - 2'd1)); // R7

  AST_LAST_BYTE_DONE: assert property (@(posedge clk) disable iff (rst)
    bus_strobe && bus_ack != 2'b00 && bus_size == 2'b01
      |=> done && !bus_strobe); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

endmodule

bind dbs_sequencer dbs_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_strobe (bus_strobe),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_wdata  (bus_wdata),
  .bus_ack    (bus_ack),
  .done       (done),
  .err        (err)
);

// File: tb/tb_dbs_sequencer.sv
module tb_dbs_sequencer;

  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = 2'b01;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              bus_strobe;
  logic              bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [15:0]       bus_wdata;
  logic [15:0]       bus_rdata = '0;
  logic [1:0]        bus_ack = 2'b00;
  logic              done;
  logic              err;
  logic [31:0]       rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [0:63];

  always #10 clk = ~clk;

  dbs_sequencer #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // one operand end to end; pws holds the port width per cycle, 2 bits each
  task automatic run_op(input string nm, input bit wr, input int n, input int a,
                        input logic [31:0] wd, input logic [15:0] pws,
                        input int waits, input bit poke);
    int rem = n;
    int ea = a;
    int cyc = 0;
    int mv;
    bit p16;
    logic [1:0] p;
    logic [31:0] exp_rd = '0;
    logic [7:0] nb, sb;
    logic [15:0] exp_l;
    logic [7:0] snap [0:63];
    for (int i = 0; i < 64; i++) snap[i] = mem[i];
    for (int i = 0; i < n; i++) exp_rd = (exp_rd << 8) | 32'(mem[a + i]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(n);
    req_addr = ADDR_W'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b0, "R3", {nm, " accepted request raised err"}, 32'(err), 0);
    while (rem > 0) begin
      chk(bus_strobe == 1'b1, "R2", {nm, " strobe"}, 32'(bus_strobe), 1);
      chk(bus_addr == ADDR_W'(ea), "R2", {nm, " address"}, 32'(bus_addr), 32'(ea));
      chk(bus_size == 2'(rem), "R2", {nm, " size code"}, 32'(bus_size), 32'(2'(rem)));
      if (wr) begin
        nb = wd[8*(rem-1) +: 8];
        sb = (rem >= 2) ? wd[8*(rem-2) +: 8] : nb;
        exp_l = ((ea % 2) == 1 || rem == 1) ? {nb, nb} : {nb, sb};
        chk(bus_wdata == exp_l, (ea % 2) ? "R7" : "R8", {nm, " write lanes"},
            32'(bus_wdata), 32'(exp_l));
      end
      if (cyc == 0) begin
        for (int w = 0; w < waits; w++) begin
          bus_ack = 2'b00;
          if (poke && w == 0) begin
            req_valid = 1'b1; req_write = ~wr; req_size = 2'b10;
            req_addr = ADDR_W'(a ^ 8); req_wdata = ~wd;
          end
          @(negedge clk);
          req_valid = 1'b0;
          chk(bus_strobe && bus_addr == ADDR_W'(ea) && bus_size == 2'(rem), "R4",
              {nm, " wait state hold"}, 32'(bus_addr), 32'(ea));
          if (poke && w == 0)
            chk(bus_addr == ADDR_W'(ea) && bus_write == wr, "R11",
                {nm, " request while busy"}, 32'(bus_addr), 32'(ea));
        end
      end
      p = pws[2*cyc +: 2];
      p16 = (p == 2'b10);
      mv = (!p16 || (ea % 2) == 1 || rem == 1) ? 1 : 2;
      bus_ack = p;
      if (p16) bus_rdata = {mem[ea & ~1], mem[ea | 1]};
      else     bus_rdata = {mem[ea], 8'h5A};
      if (wr) begin
        if (!p16) mem[ea] = bus_wdata[15:8];
        else if ((ea % 2) == 1) mem[ea] = bus_wdata[7:0];
        else if (mv == 2) begin mem[ea] = bus_wdata[15:8]; mem[ea + 1] = bus_wdata[7:0]; end
        else mem[ea] = bus_wdata[15:8];
      end
      @(negedge clk);
      bus_ack = 2'b00;
      ea += mv;
      rem -= mv;
      cyc++;
      if (rem > 0)
        chk(done == 1'b0, "R10", {nm, " early done"}, 32'(done), 0);
    end
    chk(done == 1'b1 && bus_strobe == 1'b0, "R9", {nm, " done after last byte"},
        32'({done, bus_strobe}), 32'h2);
    if (!wr) begin
      chk(rdata == exp_rd, "R9", {nm, " read operand"}, rdata, exp_rd);
    end else begin
      for (int i = 0; i < n; i++)
        chk(mem[a + i] == wd[8*(n-1-i) +: 8], "R5", {nm, " stored byte"},
            32'(mem[a + i]), 32'(wd[8*(n-1-i) +: 8]));
      if (a > 0)
        chk(mem[a - 1] == snap[a - 1], "R8", {nm, " byte below untouched"},
            32'(mem[a - 1]), 32'(snap[a - 1]));
      chk(mem[a + n] == snap[a + n], "R8", {nm, " byte above untouched"},
          32'(mem[a + n]), 32'(snap[a + n]));
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", {nm, " done is one cycle"}, 32'(done), 0);
  endtask

  task automatic test_reset();
    chk(bus_strobe == 1'b0, "R1", "strobe after reset", 32'(bus_strobe), 0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
    chk(err == 1'b0, "R1", "err after reset", 32'(err), 0);
  endtask

  task automatic test_misaligned(input string nm, input logic [1:0] sz, input int a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R3", {nm, " err pulse"}, 32'(err), 1);
    chk(bus_strobe == 1'b0, "R3", {nm, " no bus cycle"}, 32'(bus_strobe), 0);
    @(negedge clk);
    chk(err == 1'b0 && bus_strobe == 1'b0, "R3", {nm, " err one cycle"},
        32'({err, bus_strobe}), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 13 + 33);
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    // R5: long word read, 16-bit port, two cycles
    run_op("rd_long_p16", 1'b0, 4, 0, 32'h0, 16'hAAAA, 0, 1'b0);
    // R6: long word read, 8-bit port, four cycles
    run_op("rd_long_p8", 1'b0, 4, 24, 32'h0, 16'h5555, 1, 1'b0);
    // R10: 8-bit then 16-bit at odd then 16-bit pair
    run_op("rd_long_mixed", 1'b0, 4, 16, 32'h0, 16'h0029, 0, 1'b0);
    // R7: three bytes, pair then single on upper lane
    run_op("rd_three_p16", 1'b0, 3, 20, 32'h0, 16'hAAAA, 0, 1'b0);
    // R7: single byte at odd address on 16-bit port uses lower lane
    run_op("rd_byte_odd", 1'b0, 1, 7, 32'h0, 16'hAAAA, 0, 1'b0);
    // R5 write long on 16-bit port
    run_op("wr_long_p16", 1'b1, 4, 40, 32'hC1D2E3F4, 16'hAAAA, 0, 1'b0);
    // R4 R11: word write on 8-bit port with waits and a request while busy
    run_op("wr_word_p8", 1'b1, 2, 30, 32'h0000A55A, 16'h5555, 2, 1'b1);
    // R10 R8: three-byte write through an odd address
    run_op("wr_three_mixed", 1'b1, 3, 44, 32'h00123456, 16'h0029, 0, 1'b0);
    // R7 R8: byte writes at odd addresses on each port width
    run_op("wr_byte_odd_p16", 1'b1, 1, 9, 32'h0000007E, 16'hAAAA, 0, 1'b0);
    run_op("wr_byte_odd_p8", 1'b1, 1, 11, 32'h000000B3, 16'h5555, 0, 1'b0);
    // R3: multi-byte requests at odd addresses are refused
    test_misaligned("word_odd", 2'b10, 5);
    test_misaligned("long_odd", 2'b00, 13);
    test_misaligned("three_odd", 2'b11, 3);
    // R6 after errors: even word read still runs on 8-bit port
    run_op("rd_word_p8", 1'b0, 2, 50, 32'h0, 16'h5555, 0, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule